// File: doc/BRIEF.md
# Decoder Serial Stream Feeder

The feeder sits between a storage reader and a serial audio decoder. The storage side writes sector bytes one at a time into a pair of alternating sector buffers. The decoder side receives those bytes as a serial bit stream with its own data and clock lines. The decoder paces the stream through a demand line that the feeder samples only between bytes. While one buffer drains, the next sector can already be written into the other. A buffer is released for refilling only after its last byte has gone out.

Each byte is mirrored bit for bit on its way to the line. A resync pulse queues a burst of zero bytes that goes out ahead of any buffered data. The burst makes the decoder lose lock on the old stream before the new track's data arrives. A pause input freezes the stream at the next byte boundary without losing the read position.

Top module: `stream_feeder`

## Requirements
- R1: After reset `fill_rdy` is 1, `stream_empty` is 1, and `ser_clk` and `ser_data` are 0.
- R2: Each byte is bit-mirrored and then shifted out least significant bit first, so bit 7 of the written byte is the first bit on the line and bit 0 the last. `ser_data` changes only while `ser_clk` is low. A receiver samples on the rising edge of `ser_clk`. Each clock phase lasts `HALF_CLKS` cycles, so bit-to-bit rising edges are `2*HALF_CLKS` cycles apart.
- R3: A buffer counts as loaded after exactly `SECTOR_BYTES` accepted writes. It becomes free again (`fill_rdy` rises) in the cycle after the transmission of its last byte is started, when all earlier bytes of it are already on the line.
- R4: There are two buffers. A second sector may be written while the first drains. With both buffers loaded `fill_rdy` is 0, and a write made while `fill_rdy` is 0 is discarded and changes no buffered byte.
- R5: Sectors leave in the order they were loaded, and bytes within a sector leave in write order.
- R6: `demand` is sampled only between bytes. A byte already started always completes. While `demand` is 0 no new byte starts, and when it returns the stream continues at the next unsent byte.
- R7: While `pause` is 1 no new byte starts and no buffer is consumed. On release the stream resumes at the next unsent byte.
- R8: A one-cycle `resync` pulse makes the feeder send `SILENCE_BYTES` (default 256, that is 2048 bits) zero bytes, each gated by `demand` and `pause`, before any further buffered byte.
- R9: `stream_empty` is 1 exactly when no loaded buffer, no pending zero byte and no byte in flight remain. While it is 1, `ser_clk` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one sector byte |
| wr_data | input | 8 | Sector byte to write |
| fill_rdy | output | 1 | A buffer is free to accept writes |
| demand | input | 1 | Decoder wants more data |
| pause | input | 1 | Hold the stream at the next byte boundary |
| resync | input | 1 | Pulse: queue the zero-byte silence burst |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial bit clock |
| stream_empty | output | 1 | Nothing left to send |

## Verification
The bench reassembles the line into bytes and compares every sector with the pattern written into it. This catches a feeder that skips the mirroring, because its bytes arrive reversed. It also catches one that swaps buffers early, because sector order or content breaks.

It also targets the following corners:
- Dropping `demand` or raising `pause` in the middle of a sector must leave the bit count frozen on a byte boundary. Losing or repeating a byte on resume shows as a shifted sector compare.
- A write made while both buffers are full must leave both intact. A feeder that accepts it corrupts the second sector.
- The silence burst is checked for its exact length and for winning over data that was already buffered.
- The byte count at the moment a buffer is released is checked as well. A feeder that frees a buffer too early then fails.

// File: rtl/stf_pkg.sv
package stf_pkg;

    localparam int BYTE_W = 8;

    // mirror the bit order of one byte
    function automatic logic [BYTE_W-1:0] mirror8(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[BYTE_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/stf_sector_ram.sv
module stf_sector_ram #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_byte,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[wr_addr] <= wr_byte;
        end
    end

    assign rd_byte = mem_q[rd_addr];

endmodule

// File: rtl/stf_shifter.sv
module stf_shifter #(
    parameter int HALF_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] byte_in,
    output logic       busy,
    output logic       ser_data,
    output logic       ser_clk
);

    localparam int DIV_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CLKS - 1);

    typedef struct packed {
        logic [7:0]       shreg;
        logic [3:0]       bits;
        logic [DIV_W-1:0] div;
        logic             sclk;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.shreg = byte_in;
            sh_d.bits  = 4'd8;
            sh_d.div   = '0;
            sh_d.sclk  = 1'b0;
        end else if (sh_q.bits != 4'd0) begin
            if (sh_q.div == DIV_LAST) begin
                sh_d.div = '0;
                if (!sh_q.sclk) begin
                    sh_d.sclk = 1'b1;
                end else begin
                    sh_d.sclk  = 1'b0;
                    sh_d.shreg = {1'b0, sh_q.shreg[7:1]};
                    sh_d.bits  = sh_q.bits - 4'd1;
                end
            end else begin
                sh_d.div = sh_q.div + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign busy     = (sh_q.bits != 4'd0);
    assign ser_data = busy & sh_q.shreg[0];
    assign ser_clk  = sh_q.sclk;

    AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy) else $error("load while shifting"); // R6
    AST_RISE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data)) else $error("data moved at rise"); // R2
    AST_HIGH_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data)) else $error("data moved while high"); // R2

endmodule

// File: rtl/stream_feeder.sv
module stream_feeder #(
    parameter int SECTOR_BYTES  = 512,
    parameter int SILENCE_BYTES = 256,
    parameter int HALF_CLKS     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       fill_rdy,
    input  logic       demand,
    input  logic       pause,
    input  logic       resync,
    output logic       ser_data,
    output logic       ser_clk,
    output logic       stream_empty
);
    import stf_pkg::*;

    localparam int PTR_W = $clog2(SECTOR_BYTES);
    localparam int SIL_W = $clog2(SILENCE_BYTES + 1);
    localparam int AW    = PTR_W + 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(SECTOR_BYTES - 1);

    typedef struct packed {
        logic             fill_sel;
        logic             drain_sel;
        logic [1:0]       full;
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [SIL_W-1:0] sil_cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic       ram_we;
    logic [7:0] rd_byte;
    logic       sh_load;
    logic [7:0] sh_byte;
    logic       sh_busy;

    always_comb begin
        ctl_d   = ctl_q;
        ram_we  = 1'b0;
        sh_load = 1'b0;
        sh_byte = '0;

        // fill side: accept a byte only into a free buffer
        if (wr_en && !ctl_q.full[ctl_q.fill_sel]) begin
            ram_we       = 1'b1;
            ctl_d.wr_ptr = ctl_q.wr_ptr + PTR_W'(1);
            if (ctl_q.wr_ptr == PTR_LAST) begin
                ctl_d.wr_ptr                = '0;
                ctl_d.full[ctl_q.fill_sel]  = 1'b1;
                ctl_d.fill_sel              = ~ctl_q.fill_sel;
            end
        end

        // drain side: decide only at a byte boundary
        if (resync) begin
            ctl_d.sil_cnt = SIL_W'(SILENCE_BYTES);
        end else if (!pause && demand && !sh_busy) begin
            if (ctl_q.sil_cnt != '0) begin
                sh_load       = 1'b1;
                sh_byte       = '0;
                ctl_d.sil_cnt = ctl_q.sil_cnt - SIL_W'(1);
            end else if (ctl_q.full[ctl_q.drain_sel]) begin
                sh_load      = 1'b1;
                sh_byte      = mirror8(rd_byte);
                ctl_d.rd_ptr = ctl_q.rd_ptr + PTR_W'(1);
                if (ctl_q.rd_ptr == PTR_LAST) begin
                    ctl_d.rd_ptr                = '0;
                    ctl_d.full[ctl_q.drain_sel] = 1'b0;
                    ctl_d.drain_sel             = ~ctl_q.drain_sel;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    stf_sector_ram #(.DEPTH(2 * SECTOR_BYTES), .AW(AW)) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .wr_addr ({ctl_q.fill_sel, ctl_q.wr_ptr}),
        .wr_byte (wr_data),
        .rd_addr ({ctl_q.drain_sel, ctl_q.rd_ptr}),
        .rd_byte (rd_byte)
    );

    stf_shifter #(.HALF_CLKS(HALF_CLKS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .byte_in  (sh_byte),
        .busy     (sh_busy),
        .ser_data (ser_data),
        .ser_clk  (ser_clk)
    );

    assign fill_rdy     = !ctl_q.full[ctl_q.fill_sel];
    assign stream_empty = (ctl_q.full == 2'b00) && (ctl_q.sil_cnt == '0) && !sh_busy;

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !sh_busy) |=> !sh_busy) else $error("byte started in pause"); // R7
    AST_NO_DEMAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!demand && !sh_busy) |=> !sh_busy) else $error("byte started without demand"); // R6
    AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fill_rdy) |=> $stable(ctl_q.wr_ptr)) else $error("write into full buffer"); // R4
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stream_empty |-> !ser_clk) else $error("clock toggles while empty"); // R9

endmodule

// File: tb/sim_stream_feeder.sv
module sim_stream_feeder;

    localparam int CLK_PERIOD = 10;
    localparam int SECT       = 512;
    localparam int SIL        = 256;
    localparam int HALF       = 2;
    localparam int WDOG       = 195000;

    // pattern vectors: {multiplier, offset, xor mask}
    localparam logic [23:0] VEC [5] = '{
        24'h07_03_00, 24'h0D_11_5A, 24'h25_C4_81, 24'h01_00_FF, 24'h3B_77_3C
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       demand = 1'b0;
    logic       pause = 1'b0;
    logic       resync = 1'b0;
    logic       fill_rdy, ser_data, ser_clk, stream_empty;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] cap [8192];
    int         cap_n = 0;
    int         bits_seen = 0;
    logic [7:0] mon_sh = '0;
    int         last_rise = 0;
    int         last_gap = 0;

    stream_feeder #(.SECTOR_BYTES(SECT), .SILENCE_BYTES(SIL), .HALF_CLKS(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fill_rdy(fill_rdy),
        .demand(demand), .pause(pause), .resync(resync), .ser_data(ser_data),
        .ser_clk(ser_clk), .stream_empty(stream_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG && !done) begin
            done = 1'b1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < %0d", cyc, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // receiver: sample on rising edge, first bit on line is byte bit 7
    always @(posedge ser_clk) begin
        logic [7:0] nx;
        nx = {mon_sh[6:0], ser_data};
        mon_sh = nx;
        if (bits_seen % 8 != 0) last_gap = cyc - last_rise;
        last_rise = cyc;
        bits_seen = bits_seen + 1;
        if (bits_seen % 8 == 0) begin
            cap[cap_n] = nx;
            cap_n = cap_n + 1;
        end
    end

    function automatic logic [7:0] pat(int k, int i);
        int v;
        v = i * int'(VEC[k][23:16]) + int'(VEC[k][15:8]) + (i / 256) * 13;
        return 8'(v) ^ VEC[k][7:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec = n_vec + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input int k);
        for (int i = 0; i < SECT; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            while (!fill_rdy) @(negedge clk);
            wr_en = 1'b1;
            wr_data = pat(k, i);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        @(negedge clk);
        while (!stream_empty) @(negedge clk);
    endtask

    task automatic cmp_sector(input int base, input int k, input string req);
        int bad_at;
        bad_at = -1;
        for (int i = 0; i < SECT; i++) begin
            if (bad_at < 0 && cap[base + i] !== pat(k, i)) bad_at = i;
        end
        if (bad_at < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, int'(cap[base + bad_at]), int'(pat(k, bad_at)));
    endtask

    initial begin
        int base;
        int snap;
        int zeros;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(fill_rdy === 1'b1, "R1 fill_rdy", int'(fill_rdy), 1);
        check(stream_empty === 1'b1, "R1 stream_empty", int'(stream_empty), 1);
        check(ser_clk === 1'b0 && ser_data === 1'b0, "R1 serial idle", int'({ser_clk, ser_data}), 0);

        // R9: demand with nothing loaded sends nothing
        demand = 1'b1;
        repeat (60) @(negedge clk);
        check(bits_seen == 0, "R9 idle with demand", bits_seen, 0);

        // vector walk: three sectors streamed with demand held (R3 R4 R5)
        base = cap_n;
        for (int k = 0; k < 3; k++) begin
            fill(k);
            if (k == 1) begin
                check(fill_rdy === 1'b0, "R4 both buffers full", int'(fill_rdy), 0);
                while (!fill_rdy) @(negedge clk);
                check(cap_n - base == SECT - 1, "R3 release point", cap_n - base, SECT - 1);
            end
        end
        wait_empty();
        for (int k = 0; k < 3; k++) cmp_sector(base + k * SECT, k, "R5 sector order/content");
        check(last_gap == 2 * HALF, "R2 bit period", last_gap, 2 * HALF);
        check(fill_rdy === 1'b1 && stream_empty === 1'b1, "R9 empty after drain",
              int'({fill_rdy, stream_empty}), 3);

        // R4: writes into full buffers are discarded
        demand = 1'b0;
        fill(3);
        fill(4);
        check(fill_rdy === 1'b0, "R4 full flag", int'(fill_rdy), 0);
        check(stream_empty === 1'b0, "R9 not empty when loaded", int'(stream_empty), 0);
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = 8'hEE;
        end
        @(negedge clk);
        wr_en = 1'b0;
        base = cap_n;
        demand = 1'b1;
        wait_empty();
        cmp_sector(base, 3, "R4 first sector intact");
        cmp_sector(base + SECT, 4, "R4 second sector intact");

        // R7 / R6: pause and demand drop mid-sector
        demand = 1'b0;
        fill(1);
        base = cap_n;
        demand = 1'b1;
        while (cap_n - base < 20) @(negedge clk);
        pause = 1'b1;
        repeat (64) @(negedge clk);
        snap = bits_seen;
        repeat (300) @(negedge clk);
        check(bits_seen == snap && bits_seen % 8 == 0, "R7 pause freezes stream", bits_seen, snap);
        pause = 1'b0;
        while (cap_n - base < 200) @(negedge clk);
        demand = 1'b0;
        repeat (64) @(negedge clk);
        snap = bits_seen;
        repeat (300) @(negedge clk);
        check(bits_seen == snap && bits_seen % 8 == 0, "R6 demand low freezes stream", bits_seen, snap);
        demand = 1'b1;
        wait_empty();
        cmp_sector(base, 1, "R6 resume at next byte");

        // R8: silence burst ahead of buffered data
        demand = 1'b0;
        fill(2);
        @(negedge clk);
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        base = cap_n;
        demand = 1'b1;
        wait_empty();
        zeros = 0;
        for (int i = 0; i < SIL; i++) if (cap[base + i] === 8'h00) zeros++;
        check(zeros == SIL, "R8 zero burst length", zeros, SIL);
        check(cap_n - base == SIL + SECT, "R8 total bytes", cap_n - base, SIL + SECT);
        cmp_sector(base + SIL, 2, "R8 data after burst");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule